// File: doc/BRIEF.md
# Keyed Write Guard for a Memory Control Register

This block protects a memory controller's control register against stray writes. It comes out of reset locked. While it is locked, writes to the control register are accepted on the bus but have no effect. To open it, software writes two fixed key words, in order, to a separate key register. If a key value is wrong, the keys come in the wrong order, or a key is written while the register is already open, the block answers with a bus error. The register then stays locked until the next reset, and no further key sequence can open it.

Software can close the register again at any time by writing 1 to its lock bit. After such a relock, the correct key pair opens the register again. A write to the control register while the controller reports busy is stalled: ready is held low and the write has no effect until busy drops. The block sits on a simple request/ready register bus with a per-access error flag. The non-lock fields of the control register are only stored and driven out, for the controller to use.

Top module: `ctrl_reg_guard`

## Requirements
- R1: After reset the register is locked. A read of the control register (address 0x10) returns 1 in the lock bit (bit 31), and the field output is all zeros.
- R2: While the register is locked, a control register write completes with ready high and error low, and leaves the field output and bits 30:0 of the read value unchanged.
- R3: A write of 0x45670123 to the key register (address 0x04), followed by a write of 0xCDEF89AB, unlocks the register. Both writes complete without error. The lock bit then reads 0, and later control register writes load bits 30:0 into the fields.
- R4: A first key write with any value other than 0x45670123 returns a bus error and locks the register until reset.
- R5: After a correct first key, a second key write with any value other than 0xCDEF89AB returns a bus error and locks the register until reset.
- R6: A key register write while the register is unlocked returns a bus error, locks the register and keeps it locked until reset.
- R7: While the lock-until-reset is in force, every key write returns a bus error, and the correct key pair does not unlock the register.
- R8: Writing the control register with bit 31 set while the register is unlocked locks it again. Bits 30:0 of that same write are still loaded. The correct key pair then unlocks the register again.
- R9: A control register write issued while busy_i is high keeps ready low and has no effect. It completes in the first cycle busy_i is low.
- R10: Reads and control register accesses made between the two key writes do not disturb the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Write data |
| busy_i | input | 1 | Controller operation in progress |
| rdata_o | output | 32 | Read data |
| ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Bus error for the completing access |
| ctrl_o | output | 31 | Control register fields other than the lock bit |

## Verification
The case of interest is a control register write that carries a set lock bit while busy_i is high. Here a stall and a relock are pending together, and the relock must not take effect before the stall ends. The bench holds busy high for one to three cycles on random control writes, some with bit 31 set. During the stall it checks that ready stays low and the fields do not move. After busy drops, it reads the lock bit back and compares it with the model, which relocks only at completion.

// File: rtl/ctrl_guard_pkg.sv
package ctrl_guard_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB;

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_FROZEN = 2'd3
  } key_state_e;
endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
  import ctrl_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_data_i,
  input  logic              relock_i,
  output logic              unlocked_o,
  output logic              frozen_o,
  output logic              key_err_o
);
  key_state_e state_q, state_d;
  logic       key_ok;

  always_comb begin
    unique case (state_q)
      KS_IDLE: key_ok = (key_data_i == KEY_FIRST);
      KS_HALF: key_ok = (key_data_i == KEY_SECOND);
      default: key_ok = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      if (!key_ok)                 state_d = KS_FROZEN;
      else if (state_q == KS_IDLE) state_d = KS_HALF;
      else                         state_d = KS_OPEN;
    end else if (relock_i && state_q == KS_OPEN) begin
      state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == KS_OPEN);
  assign frozen_o   = (state_q == KS_FROZEN);
  assign key_err_o  = key_wr_i && !key_ok;
endmodule

// File: rtl/ctrl_field_reg.sv
module ctrl_field_reg #(
  parameter int unsigned FIELD_W = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] fields_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fields_o <= '0;
    else if (wr_en_i) fields_o <= wdata_i;
  end
endmodule

// File: rtl/ctrl_reg_guard.sv
module ctrl_reg_guard
  import ctrl_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h04,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter int unsigned LOCK_BIT  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic [30:0]       ctrl_o
);
  localparam int unsigned FIELD_W = DATA_W - 1;

  logic               key_hit, ctrl_hit, ctrl_stall;
  logic               key_wr, ctrl_wr, field_wr, relock;
  logic               unlocked, frozen;
  logic [FIELD_W-1:0] wr_fields, fields;
  logic [DATA_W-1:0]  ctrl_view;

  assign key_hit    = req_i && (addr_i == KEY_ADDR);
  assign ctrl_hit   = req_i && (addr_i == CTRL_ADDR);
  assign ctrl_stall = ctrl_hit && we_i && busy_i;
  assign key_wr     = key_hit && we_i;
  assign ctrl_wr    = ctrl_hit && we_i && !busy_i;
  assign field_wr   = ctrl_wr && unlocked;
  assign relock     = field_wr && wdata_i[LOCK_BIT];

  // strip / insert the lock bit at LOCK_BIT
  always_comb begin
    wr_fields = '0;
    ctrl_view = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (i < int'(LOCK_BIT)) begin
        wr_fields[i] = wdata_i[i];
        ctrl_view[i] = fields[i];
      end else if (i > int'(LOCK_BIT)) begin
        wr_fields[i-1] = wdata_i[i];
        ctrl_view[i]   = fields[i-1];
      end else begin
        ctrl_view[i] = !unlocked;
      end
    end
  end

  key_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_data_i (wdata_i),
    .relock_i   (relock),
    .unlocked_o (unlocked),
    .frozen_o   (frozen),
    .key_err_o  (err_o)
  );

  ctrl_field_reg #(.FIELD_W(FIELD_W)) u_fields (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (field_wr),
    .wdata_i  (wr_fields),
    .fields_o (fields)
  );

  assign ready_o = req_i && !ctrl_stall;
  assign rdata_o = (ctrl_hit && !we_i) ? ctrl_view : '0;
  assign ctrl_o  = fields;
endmodule

// File: rtl/ctrl_reg_guard_chk.sv
module ctrl_reg_guard_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h04,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              busy_i,
  input logic              ready_o,
  input logic              err_o,
  input logic [30:0]       ctrl_o,
  input logic              unlocked,
  input logic              frozen
);
  logic key_wr, ctrl_wr;
  assign key_wr  = req_i && we_i && addr_i == KEY_ADDR;
  assign ctrl_wr = req_i && we_i && addr_i == CTRL_ADDR;

  // R2
  locked_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !unlocked) |=> $stable(ctrl_o));

  // R9
  stalled_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy_i) |=> $stable(ctrl_o));

  // R3
  unlock_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked) |-> $past(key_wr && wdata_i == 32'hCDEF_89AB));

  // R7
  frozen_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> frozen);

  // R7
  frozen_key_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && key_wr) |-> err_o);

  // R4
  err_is_completion_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && key_wr));

  // R6
  err_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (frozen && !unlocked));
endmodule

bind ctrl_reg_guard ctrl_reg_guard_chk #(
  .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .busy_i(busy_i),
  .ready_o(ready_o), .err_o(err_o), .ctrl_o(ctrl_o),
  .unlocked(unlocked), .frozen(frozen)
);

// File: tb/ctrl_reg_guard_tb.sv
module ctrl_reg_guard_tb;
  localparam logic [7:0]  KEY_A  = 8'h04;
  localparam logic [7:0]  CTRL_A = 8'h10;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, busy_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o, err_o;
  logic [30:0] ctrl_o;

  int checks = 0, failures = 0;
  int m_state = 0;            // 0 idle, 1 half, 2 open, 3 frozen
  logic [30:0] m_fields = '0;

  always #2 clk_i = ~clk_i;   // 250 MHz

  ctrl_reg_guard u_dut (.*);

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; req_i = 1'b0; busy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_state = 0; m_fields = '0;
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input int stall, output logic e, output logic [31:0] rd);
    logic [30:0] held;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; busy_i = (stall > 0);
    held = ctrl_o;
    for (int k = 0; k < stall; k++) begin
      #1;
      chk(ready_o == 1'b0, "R9 stall ready", 32'(ready_o), 0);
      chk(ctrl_o == held, "R9 stall fields", 32'(ctrl_o), 32'(held));
      @(negedge clk_i);
    end
    busy_i = 1'b0;
    #1;
    chk(ready_o == 1'b1, "R9 completion ready", 32'(ready_o), 1);
    e = err_o; rd = rdata_o;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  function automatic bit exp_key_err(input logic [31:0] d);
    return !((m_state == 0 && d == K1) || (m_state == 1 && d == K2));
  endfunction

  task automatic key_wr(input logic [31:0] d, input string r);
    logic e; logic [31:0] rd;
    bit xe = exp_key_err(d);
    bus(1'b1, KEY_A, d, 0, e, rd);
    chk(e == xe, r, 32'(e), 32'(xe));
    if (xe) m_state = 3;
    else    m_state = m_state + 1;
  endtask

  task automatic ctrl_wr(input logic [31:0] d, input int stall, input string r);
    logic e; logic [31:0] rd;
    bus(1'b1, CTRL_A, d, stall, e, rd);
    chk(e == 1'b0, r, 32'(e), 0);
    if (m_state == 2) begin
      m_fields = d[30:0];
      if (d[31]) m_state = 0;
    end
  endtask

  task automatic ctrl_rd(input string r);
    logic e; logic [31:0] rd;
    logic [31:0] x;
    bus(1'b0, CTRL_A, 32'h0, 0, e, rd);
    x = {m_state != 2, m_fields};
    chk(rd == x, r, rd, x);
    chk(ctrl_o == m_fields, r, 32'(ctrl_o), 32'(m_fields));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic e; logic [31:0] rd;
    void'($urandom(32'h5eed_1234));
    do_reset();
    ctrl_rd("R1 reset");
    ctrl_wr(32'h0000_00ff, 0, "R2 locked write");
    ctrl_rd("R2 locked no effect");
    key_wr(K1, "R3 key1");
    ctrl_rd("R10 between keys");
    ctrl_wr(32'h1234_5678, 0, "R10 ctrl between keys");
    key_wr(K2, "R3 key2");
    ctrl_rd("R3 unlocked");
    ctrl_wr(32'h0abc_def0, 0, "R3 write fields");
    ctrl_rd("R3 fields loaded");
    ctrl_wr(32'h8000_0055, 2, "R9 stalled relock");
    ctrl_rd("R8 relocked");
    key_wr(K1, "R8 key1 again"); key_wr(K2, "R8 key2 again");
    ctrl_rd("R8 unlocked again");
    key_wr(K1, "R6 key while open");
    ctrl_rd("R6 frozen");
    key_wr(K1, "R7 key1 frozen"); key_wr(K2, "R7 key2 frozen");
    ctrl_rd("R7 still locked");
    do_reset();
    key_wr(K2, "R4 wrong first");
    ctrl_rd("R4 frozen");
    do_reset();
    key_wr(K1, "R5 key1"); key_wr(K1, "R5 wrong second");
    ctrl_rd("R5 frozen");
    do_reset();
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 12;
      if (op < 3) begin
        logic [31:0] d;
        if ($urandom % 8 != 0) d = (m_state == 1) ? K2 : K1;
        else d = $urandom;
        key_wr(d, "R4 R5 R6 R7 random key");
      end else if (op < 7) begin
        logic [31:0] d = $urandom;
        d[31] = ($urandom % 4 == 0);
        ctrl_wr(d, ($urandom % 3 == 0) ? int'($urandom % 3) + 1 : 0, "R2 R8 R9 random ctrl");
      end else if (op < 10) begin
        ctrl_rd("R1 R3 R8 random read");
      end else if (op == 10) begin
        bus(1'b0, 8'h20, 32'h0, 0, e, rd);
        chk(e == 1'b0, "R10 other read", 32'(e), 0);
      end else if ($urandom % 4 == 0) begin
        do_reset();
        ctrl_rd("R1 random reset");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule